// File: doc/BRIEF.md
# Suspend Resume Event Controller

This block owns the wake-up side of a mobile chipset's suspend logic. Software enters suspend with a one-cycle request strobe. The block then raises a suspend status flag, and board logic uses that flag to switch off power planes. While suspended, the block watches four active-low wake sources: a serial ring-indicate line, an external event line, a real-time-clock alarm and a suspend/resume button. It also watches a battery-low line that can hold off a wake.

Each wake source except the button has a mask bit, and the battery-low gate has a bit of its own. A masked source cannot wake the system. During suspend, a masked ring-indicate or external-event pin also has its internal pull-up turned off, so that an unpowered driver is never back-fed. When a wake is accepted, the block does three things:
- it pulses a resume strobe,
- it drops suspend status,
- it latches a one-hot cause that software reads and clears by writing ones.

The RTC alarm is held in a pending flag until software strobes a clear. That strobe stands for the read of the clock's status register at I/O offset 0Ch.

Two resets apply. The bus reset restores only the masks. The resume-well reset clears everything.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After a bus reset or a resume-well reset, `mask_o` reads 4'b0001. Bit 0 masks ring-indicate, bit 1 masks the external event, bit 2 masks the RTC alarm, and bit 3 is the battery-low override. A 1 means masked, or for bit 3 that battery-low is ignored.
- R2: A cycle with `mask_we_i` high loads `mask_wdata_i` into the masks, visible on `mask_o` after that clock edge.
- R3: While awake, a one-cycle `susp_req_i` sets `susp_o` from the following clock edge. It stays set until a wake is accepted.
- R4: `pullup_en_o` bit 0 (ring-indicate) and bit 1 (external event) are low only while `susp_o` is high and the matching mask bit is 1. Otherwise they are high.
- R5: While suspended, an unmasked ring-indicate or external-event input held low produces a one-cycle `resume_o` three clock edges after it falls: two synchronizer stages plus the decision register. `susp_o` drops in the same cycle. A masked source held low causes no resume.
- R6: On a resume, `cause_o` is one-hot: bit 0 ring-indicate, bit 1 external event, bit 2 RTC alarm, bit 3 button. Priority is ring > external > RTC among the unmasked active sources. The button is unmaskable and is reported when none of the other three is flagged.
- R7: With mask bit 3 clear, an asserted battery-low input blocks every wake until it is released. With bit 3 set, battery-low has no effect.
- R8: A low level on the RTC alarm input sets a pending flag, even while awake. The flag stays set until `rtc_clr_i` is strobed. An unmasked pending alarm wakes the system two edges after the suspend request.
- R9: A cycle with `cause_clr_we_i` high clears each `cause_o` bit whose `cause_clr_i` bit is 1 and leaves the other bits unchanged. A resume in the same cycle takes precedence.
- R10: The resume-well reset clears `susp_o`, `resume_o`, `cause_o` and the RTC pending flag, and restores the mask defaults.
- R11: The bus reset restores the mask defaults but leaves `cause_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| wrst_ni | input | 1 | Resume-well reset, active low, asynchronous |
| ring_n_i | input | 1 | Ring-indicate wake source, active low, asynchronous |
| ext_evt_n_i | input | 1 | External event wake source, active low, asynchronous |
| rtc_alarm_n_i | input | 1 | RTC alarm interrupt, active low, asynchronous |
| button_n_i | input | 1 | Suspend/resume button, active low, asynchronous |
| batt_low_n_i | input | 1 | Battery-low indication, active low, asynchronous |
| susp_req_i | input | 1 | Software suspend request strobe |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 4 | Mask register write data |
| mask_o | output | 4 | Mask register read value |
| cause_clr_we_i | input | 1 | Cause register write-one-to-clear enable |
| cause_clr_i | input | 4 | Cause bits to clear |
| cause_o | output | 4 | One-hot resume cause |
| rtc_clr_i | input | 1 | Clears the pending RTC alarm |
| susp_o | output | 1 | Suspend status |
| resume_o | output | 1 | One-cycle resume strobe |
| pullup_en_o | output | 2 | Internal pull-up enables (bit 0 ring, bit 1 external) |

## Verification
A wake driven on a pin lands on `resume_o` and `cause_o` three edges after the pin changes. A pending RTC alarm lands two edges after the suspend request, since it bypasses the synchronizer at that moment. Mask writes, cause clears and suspend entry are visible one edge after their strobe. Each stimulus task pushes the expected cause and the exact due cycle into a queue. The monitor samples on the falling clock edge and fails any resume that comes early, late, unexpected or with the wrong cause. Checks that a blocked or masked source does not wake watch `susp_o` for several cycles beyond the three-edge latency.

// File: rtl/susp_wake_pkg.sv
package susp_wake_pkg;
  localparam int NSRC   = 4;  // cause width: ring, ext, rtc, button
  localparam int NMASK  = 4;  // ring, ext, rtc, battery override
  localparam int NPIN   = 5;  // synchronized raw inputs
  localparam int NPULL  = 2;  // pins with internal pull-ups
  localparam int C_RING = 0;
  localparam int C_EXT  = 1;
  localparam int C_RTC  = 2;
  localparam int C_BTN  = 3;
  localparam int M_BATT = 3;
  localparam int P_BTN  = 3;
  localparam int P_BATT = 4;
  localparam logic [NMASK-1:0] MASK_DEFAULT = 4'b0001;

  typedef enum logic {ST_AWAKE = 1'b0, ST_SUSP = 1'b1} pm_state_e;

  // lowest index wins; button when nothing else flagged
  function automatic logic [NSRC-1:0] pick_cause(input logic [NSRC-2:0] flags);
    logic [NSRC-1:0] c;
    c = '0;
    c[C_BTN] = 1'b1;
    for (int i = NSRC-2; i >= 0; i--) begin
      if (flags[i]) begin
        c    = '0;
        c[i] = 1'b1;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  // inputs are active low: reset to idle-high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wake_mask_regs.sv
module wake_mask_regs
  import susp_wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NMASK-1:0] wdata_i,
  output logic [NMASK-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= MASK_DEFAULT;
    else if (we_i) mask_o <= wdata_i;
  end

  p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o == $past(wdata_i));
endmodule

// File: rtl/wake_rtc_flag.sv
module wake_rtc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic clr_i,
  output logic pend_o
);
  // a live alarm overrides the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= 1'b0;
    else if (alarm_i) pend_o <= 1'b1;
    else if (clr_i)   pend_o <= 1'b0;
  end

  p_rtc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/wake_cause.sv
module wake_cause
  import susp_wake_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [NSRC-1:0] set_val_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_o <= '0;
    else if (set_i)    cause_o <= set_val_i;
    else if (clr_we_i) cause_o <= cause_o & ~clr_i;
  end

  p_cause_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));
  p_cause_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_i) |=> (cause_o & $past(clr_i)) == '0);
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
  import susp_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrst_ni,
  input  logic             ring_n_i,
  input  logic             ext_evt_n_i,
  input  logic             rtc_alarm_n_i,
  input  logic             button_n_i,
  input  logic             batt_low_n_i,
  input  logic             susp_req_i,
  input  logic             mask_we_i,
  input  logic [NMASK-1:0] mask_wdata_i,
  output logic [NMASK-1:0] mask_o,
  input  logic             cause_clr_we_i,
  input  logic [NSRC-1:0]  cause_clr_i,
  output logic [NSRC-1:0]  cause_o,
  input  logic             rtc_clr_i,
  output logic             susp_o,
  output logic             resume_o,
  output logic [NPULL-1:0] pullup_en_o
);
  logic            mask_rst_n;
  logic [NPIN-1:0] pin_raw, pin_sync, act;
  logic            rtc_pend;
  logic [NSRC-2:0] flags;
  logic            any_evt, batt_ok, wake;
  logic [NSRC-1:0] cause_next;
  pm_state_e       st_q;
  logic            resume_q;

  // bus reset restores masks only; well reset clears all
  assign mask_rst_n = rst_ni & wrst_ni;

  assign pin_raw = {batt_low_n_i, button_n_i, rtc_alarm_n_i, ext_evt_n_i, ring_n_i};

  wake_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(wrst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );
  assign act = ~pin_sync;

  wake_mask_regs i_mask (
    .clk_i  (clk_i),
    .rst_ni (mask_rst_n),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .mask_o (mask_o)
  );

  wake_rtc_flag i_rtc (
    .clk_i  (clk_i),
    .rst_ni (wrst_ni),
    .alarm_i(act[C_RTC]),
    .clr_i  (rtc_clr_i),
    .pend_o (rtc_pend)
  );

  assign flags[C_RING] = act[C_RING] & ~mask_o[C_RING];
  assign flags[C_EXT]  = act[C_EXT]  & ~mask_o[C_EXT];
  assign flags[C_RTC]  = rtc_pend    & ~mask_o[C_RTC];
  assign any_evt       = (|flags) | act[P_BTN];
  assign batt_ok       = ~act[P_BATT] | mask_o[M_BATT];
  assign wake          = (st_q == ST_SUSP) & any_evt & batt_ok;
  assign cause_next    = pick_cause(flags);

  always_ff @(posedge clk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      st_q     <= ST_AWAKE;
      resume_q <= 1'b0;
    end else begin
      resume_q <= wake;
      case (st_q)
        ST_AWAKE: if (susp_req_i) st_q <= ST_SUSP;
        ST_SUSP:  if (wake)       st_q <= ST_AWAKE;
        default:                  st_q <= ST_AWAKE;
      endcase
    end
  end

  wake_cause i_cause (
    .clk_i    (clk_i),
    .rst_ni   (wrst_ni),
    .set_i    (wake),
    .set_val_i(cause_next),
    .clr_we_i (cause_clr_we_i),
    .clr_i    (cause_clr_i),
    .cause_o  (cause_o)
  );

  genvar g;
  generate
    for (g = 0; g < NPULL; g++) begin : g_pull
      assign pullup_en_o[g] = ~((st_q == ST_SUSP) & mask_o[g]);
    end
  endgenerate

  assign susp_o   = (st_q == ST_SUSP);
  assign resume_o = resume_q;

  p_susp_entry_r3: assert property (@(posedge clk_i) disable iff (!wrst_ni)
    (!susp_o && susp_req_i) |=> susp_o);
  p_pullup_awake_r4: assert property (@(posedge clk_i) disable iff (!wrst_ni)
    !susp_o |-> pullup_en_o == '1);
  p_resume_from_susp_r5: assert property (@(posedge clk_i) disable iff (!wrst_ni)
    resume_o |-> ($past(susp_o) && !susp_o));
  p_resume_pulse_r5: assert property (@(posedge clk_i) disable iff (!wrst_ni)
    resume_o |=> !resume_o);
  p_batt_hold_r7: assert property (@(posedge clk_i) disable iff (!wrst_ni || !rst_ni)
    (susp_o && act[P_BATT] && !mask_o[M_BATT]) |=> susp_o);
endmodule

// File: tb/test_susp_wake_ctrl.sv
module test_susp_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni, wrst_ni;
  logic       ring_n, ext_n, rtc_n, btn_n, batt_n;
  logic       susp_req, mask_we, cause_clr_we, rtc_clr;
  logic [3:0] mask_wdata, cause_clr, mask_o, cause_o;
  logic       susp_o, resume_o;
  logic [1:0] pullup_en_o;

  typedef struct {
    logic [3:0] cause;
    int         due;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  susp_wake_ctrl i_susp_wake_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrst_ni(wrst_ni),
    .ring_n_i(ring_n), .ext_evt_n_i(ext_n), .rtc_alarm_n_i(rtc_n),
    .button_n_i(btn_n), .batt_low_n_i(batt_n),
    .susp_req_i(susp_req), .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .mask_o(mask_o), .cause_clr_we_i(cause_clr_we), .cause_clr_i(cause_clr),
    .cause_o(cause_o), .rtc_clr_i(rtc_clr), .susp_o(susp_o),
    .resume_o(resume_o), .pullup_en_o(pullup_en_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic expect_wake(input logic [3:0] cause, input int lat, input string tag);
    exp_t e;
    e.cause = cause;
    e.due   = cyc + lat;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic go_suspend();
    susp_req = 1'b1;
    step();
    susp_req = 1'b0;
  endtask

  task automatic write_mask(input logic [3:0] v);
    mask_wdata = v;
    mask_we    = 1'b1;
    step();
    mask_we    = 1'b0;
  endtask

  task automatic clear_cause(input logic [3:0] v);
    cause_clr    = v;
    cause_clr_we = 1'b1;
    step();
    cause_clr_we = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (resume_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 unexpected resume: actual cause %b expected no resume (cycle %0d)", cause_o, cyc);
      end else begin
        automatic exp_t e = exp_q.pop_front();
        if (cyc != e.due || cause_o !== e.cause || susp_o !== 1'b0) begin
          n_fail++;
          $display("FAIL %s: actual cycle %0d cause %b susp %b expected cycle %0d cause %b susp 0",
                   e.tag, cyc, cause_o, susp_o, e.due, e.cause);
        end
      end
    end else if (exp_q.size() > 0 && cyc > exp_q[0].due) begin
      automatic exp_t e = exp_q.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s: actual no resume by cycle %0d expected resume at cycle %0d", e.tag, cyc, e.due);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual run still busy expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wrst_ni = 1'b0;
    {ring_n, ext_n, rtc_n, btn_n, batt_n} = '1;
    {susp_req, mask_we, cause_clr_we, rtc_clr} = '0;
    mask_wdata = '0; cause_clr = '0;
    step(3);
    rst_ni = 1'b1; wrst_ni = 1'b1;
    step(2);
    chk("R1 mask default", mask_o, 4'b0001);
    chk("R10 reset susp", susp_o, 0);
    chk("R10 reset cause", cause_o, 0);
    chk("R4 pullups awake", pullup_en_o, 2'b11);

    go_suspend();
    chk("R3 suspend entry", susp_o, 1);
    chk("R4 masked ring pullup off", pullup_en_o, 2'b10);

    ring_n = 1'b0;            // masked: ignored
    step(6);
    chk("R5 masked ring ignored", susp_o, 1);
    ring_n = 1'b1;
    step(4);

    expect_wake(4'b0010, 3, "R5 ext wake");
    ext_n = 1'b0;
    step(4);
    ext_n = 1'b1;
    chk("R5 awake after ext", susp_o, 0);
    chk("R4 pullups after wake", pullup_en_o, 2'b11);
    chk("R6 ext cause", cause_o, 4'b0010);

    clear_cause(4'b0001);
    chk("R9 other bit kept", cause_o, 4'b0010);
    clear_cause(4'b0010);
    chk("R9 bit cleared", cause_o, 4'b0000);

    write_mask(4'b0000);
    chk("R2 mask write", mask_o, 4'b0000);
    step(3);

    go_suspend();
    chk("R4 unmasked pullups on", pullup_en_o, 2'b11);
    expect_wake(4'b0001, 3, "R6 ring over ext");
    ring_n = 1'b0; ext_n = 1'b0;
    step(4);
    ring_n = 1'b1; ext_n = 1'b1;
    step(4);

    go_suspend();
    expect_wake(4'b1000, 3, "R6 button");
    btn_n = 1'b0;
    step(4);
    btn_n = 1'b1;
    step(4);

    // alarm while awake leaves a pending flag
    rtc_n = 1'b0;
    step(4);
    rtc_n = 1'b1;
    step(4);
    chk("R8 no wake while awake", susp_o, 0);
    expect_wake(4'b0100, 2, "R8 pending alarm wake");
    go_suspend();
    step(4);
    expect_wake(4'b0100, 2, "R8 alarm still pending");
    go_suspend();
    step(4);
    rtc_clr = 1'b1;
    step();
    rtc_clr = 1'b0;
    go_suspend();
    step(5);
    chk("R8 cleared alarm no wake", susp_o, 1);
    expect_wake(4'b1000, 3, "R8 button after clear");
    btn_n = 1'b0;
    step(4);
    btn_n = 1'b1;
    step(4);

    go_suspend();
    batt_n = 1'b0;
    step(3);
    ring_n = 1'b0;
    step(6);
    chk("R7 battery blocks wake", susp_o, 1);
    expect_wake(4'b0001, 3, "R7 wake on battery release");
    batt_n = 1'b1;
    step(4);
    ring_n = 1'b1;
    step(4);

    write_mask(4'b1000);
    go_suspend();
    batt_n = 1'b0;
    step(3);
    expect_wake(4'b0010, 3, "R7 override ignores battery");
    ext_n = 1'b0;
    step(4);
    ext_n = 1'b1; batt_n = 1'b1;
    step(4);

    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    step();
    chk("R11 bus reset mask", mask_o, 4'b0001);
    chk("R11 bus reset keeps cause", cause_o, 4'b0010);

    write_mask(4'b0110);
    go_suspend();
    wrst_ni = 1'b0;
    step();
    wrst_ni = 1'b1;
    step();
    chk("R10 well reset susp", susp_o, 0);
    chk("R10 well reset cause", cause_o, 0);
    chk("R10 well reset mask", mask_o, 4'b0001);

    step(5);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule